// File: doc/BRIEF.md
# Cut-Through Virtual Channel Buffer Admission

This block keeps the free-space account for the virtual channels of one router input port that uses virtual cut-through flow control. A sender asks to forward a packet by giving its packet class, a lane (VC) number within that class and the packet length in bytes. The block grants the request in the same cycle only if the whole packet fits in the free space of the target VC buffer. On a grant it debits that space. Later, a buffer-deallocation return gives the space back through a separate credit port.

There are seven packet classes. Six general classes each own three lanes. The special class owns a single lane. That makes nineteen VCs per port. Space is counted in 4-byte phits, and the length of a packet is rounded up to whole phits. Every VC holds `CAP_PHITS` phits. The current free space of all VCs can be read at any time on a flat output vector. Switch arbitration, packet storage and routing are outside this block.

Top module: `vc_admit`

## Requirements
- R1: Class codes are 0 request, 1 forward, 2 block response, 3 nonblock response, 4 write I/O, 5 read I/O, 6 special, and 7 is illegal. Classes 0 to 5 accept lanes 0 to 2, and class 6 accepts lane 0 only. A legal pair maps to VC index class*3+lane, and special lane 0 maps to index 18. An illegal pair is never granted.
- R2: `req_grant` is high in the same cycle as `req_valid` if and only if the pair is legal and ceil(`req_len`/4) is not greater than the current free space of that VC. A packet that only partly fits is refused.
- R3: After a grant, the free space of the granted VC is lower by ceil(`req_len`/4) phits from the next clock edge. A refused request changes no free space.
- R4: A return with a legal pair whose amount keeps free space at or below `CAP_PHITS` adds `ret_phits` to that VC from the next clock edge.
- R5: A return raises `ret_err` in the same cycle if its pair is illegal or if the current free space plus `ret_phits` exceeds `CAP_PHITS`. Such a return changes no free space.
- R6: When a request and a return name the same VC in the same cycle, the grant is decided on the free space before the return. Both the debit and the credit are then applied at the same edge.
- R7: Reset sets every VC to `CAP_PHITS`. VC index k is read at bits [k*CNT_W +: CNT_W] of `free_flat`.
- R8: Free space never exceeds `CAP_PHITS`. With no grant and no return, `free_flat` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Forward request present |
| req_class | input | 3 | Packet class of the request |
| req_lane | input | 2 | Lane within the class |
| req_len | input | LEN_W | Packet length in bytes |
| req_grant | output | 1 | Whole packet fits; space is debited |
| ret_valid | input | 1 | Buffer-deallocation return present |
| ret_class | input | 3 | Class of the returned space |
| ret_lane | input | 2 | Lane of the returned space |
| ret_phits | input | CNT_W | Phits returned |
| ret_err | output | 1 | Illegal or overflowing return, ignored |
| free_flat | output | 19*CNT_W | Free phits of every VC |

## Verification
Every VC count is visible on `free_flat`, so a wrong debit, a lost credit or a credit applied to the wrong VC appears on the port one edge after the event. A stale count that is never read directly still shows up within one cycle as a wrong `req_grant` or `ret_err` decision, because both are combinational on the current count. For this reason the bench compares the full vector and both decision outputs on every cycle. It also targets the exact-fit boundary, the same-VC collision, overflow by one phit and a reset in mid-run.

// File: rtl/vc_admit_pkg.sv
package vc_admit_pkg;
  localparam int unsigned CLASS_W         = 3;
  localparam int unsigned LANE_W          = 2;
  localparam int unsigned LANES_PER_CLASS = 3;
  localparam int unsigned GENERAL_CLASSES = 6;
  localparam int unsigned NUM_VC          = GENERAL_CLASSES * LANES_PER_CLASS + 1;
  localparam int unsigned IDX_W           = $clog2(NUM_VC);
  localparam int unsigned PHIT_BYTES      = 4;
  localparam int unsigned PHIT_SH         = $clog2(PHIT_BYTES);

  typedef enum logic [CLASS_W-1:0] {
    PC_REQ     = 3'd0,
    PC_FWD     = 3'd1,
    PC_BLK_RSP = 3'd2,
    PC_NB_RSP  = 3'd3,
    PC_IO_WR   = 3'd4,
    PC_IO_RD   = 3'd5,
    PC_SPECIAL = 3'd6,
    PC_NONE    = 3'd7
  } pkt_class_e;

  typedef logic [IDX_W-1:0] vc_idx_t;
endpackage

// File: rtl/vc_admit_map.sv
module vc_admit_map
  import vc_admit_pkg::*;
(
  input  logic [CLASS_W-1:0] cls_i,
  input  logic [LANE_W-1:0]  lane_i,
  output vc_idx_t            idx_o,
  output logic               legal_o
);
  localparam logic [CLASS_W-1:0] GEN_CLS  = CLASS_W'(GENERAL_CLASSES);
  localparam logic [LANE_W-1:0]  LANE_LIM = LANE_W'(LANES_PER_CLASS);
  localparam vc_idx_t            SPC_IDX  = IDX_W'(NUM_VC - 1);

  always_comb begin
    idx_o   = '0;
    legal_o = 1'b0;
    if (cls_i < GEN_CLS) begin
      if (lane_i < LANE_LIM) begin
        legal_o = 1'b1;
        idx_o   = IDX_W'(cls_i) * IDX_W'(LANES_PER_CLASS) + IDX_W'(lane_i);
      end
    end else if (cls_i == PC_SPECIAL && lane_i == '0) begin
      legal_o = 1'b1;
      idx_o   = SPC_IDX;
    end
  end
endmodule

// File: rtl/vc_admit_len2phit.sv
module vc_admit_len2phit
  import vc_admit_pkg::*;
#(
  parameter  int unsigned LEN_W = 7,
  localparam int unsigned OUT_W = LEN_W + 1 - PHIT_SH
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [OUT_W-1:0] phits_o
);
  logic [LEN_W:0] rounded;

  always_comb begin
    rounded = {1'b0, len_i} + (LEN_W+1)'(PHIT_BYTES - 1);
    phits_o = rounded[LEN_W:PHIT_SH];
  end
endmodule

// File: rtl/vc_admit_slot.sv
module vc_admit_slot #(
  parameter  int unsigned CAP   = 24,
  parameter  int unsigned CNT_W = 5,
  parameter  int unsigned AMT_W = 6,
  localparam int unsigned SUM_W = ((CNT_W > AMT_W) ? CNT_W : AMT_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AMT_W-1:0] take_amt_i,
  input  logic             take_i,
  input  logic             give_i,
  input  logic [CNT_W-1:0] give_amt_i,
  output logic             fit_o,
  output logic             give_ovf_o,
  output logic [CNT_W-1:0] free_o
);
  localparam logic [SUM_W-1:0] CAP_X = SUM_W'(CAP);

  logic [CNT_W-1:0] free_q, free_d;
  logic [SUM_W-1:0] free_x, take_x, give_x, next_x;
  logic             upd_en;

  always_comb begin
    free_x     = SUM_W'(free_q);
    take_x     = SUM_W'(take_amt_i);
    give_x     = SUM_W'(give_amt_i);
    fit_o      = (take_x <= free_x);
    give_ovf_o = give_i && ((free_x + give_x) > CAP_X);
    next_x     = free_x;
    if (take_i) begin
      next_x = next_x - take_x;
    end
    if (give_i && !give_ovf_o) begin
      next_x = next_x + give_x;
    end
    free_d = next_x[CNT_W-1:0];
    upd_en = take_i || (give_i && !give_ovf_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= CNT_W'(CAP);
    end else if (upd_en) begin
      free_q <= free_d;
    end
  end

  assign free_o = free_q;
endmodule

// File: rtl/vc_admit.sv
module vc_admit
  import vc_admit_pkg::*;
#(
  parameter  int unsigned CAP_PHITS = 24,
  parameter  int unsigned LEN_W     = 7,
  localparam int unsigned CNT_W     = $clog2(CAP_PHITS + 1),
  localparam int unsigned AMT_W     = LEN_W + 1 - PHIT_SH
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [2:0]              req_class,
  input  logic [1:0]              req_lane,
  input  logic [LEN_W-1:0]        req_len,
  output logic                    req_grant,
  input  logic                    ret_valid,
  input  logic [2:0]              ret_class,
  input  logic [1:0]              ret_lane,
  input  logic [CNT_W-1:0]        ret_phits,
  output logic                    ret_err,
  output logic [NUM_VC*CNT_W-1:0] free_flat
);
  localparam int unsigned IDX_SPAN = 2 ** IDX_W;

  vc_idx_t              req_idx, ret_idx;
  logic                 req_legal, ret_legal;
  logic [AMT_W-1:0]     req_phits;
  logic [IDX_SPAN-1:0]  fit_vec;
  logic [NUM_VC-1:0]    ovf_vec;

  vc_admit_map u_req_map (
    .cls_i   (req_class),
    .lane_i  (req_lane),
    .idx_o   (req_idx),
    .legal_o (req_legal)
  );

  vc_admit_map u_ret_map (
    .cls_i   (ret_class),
    .lane_i  (ret_lane),
    .idx_o   (ret_idx),
    .legal_o (ret_legal)
  );

  vc_admit_len2phit #(.LEN_W(LEN_W)) u_len (
    .len_i   (req_len),
    .phits_o (req_phits)
  );

  assign fit_vec[IDX_SPAN-1:NUM_VC] = '0;

  for (genvar g = 0; g < NUM_VC; g++) begin : g_slot
    logic take_here, give_here;
    assign take_here = req_grant && (req_idx == vc_idx_t'(g));
    assign give_here = ret_valid && ret_legal && (ret_idx == vc_idx_t'(g));

    vc_admit_slot #(
      .CAP   (CAP_PHITS),
      .CNT_W (CNT_W),
      .AMT_W (AMT_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_amt_i (req_phits),
      .take_i     (take_here),
      .give_i     (give_here),
      .give_amt_i (ret_phits),
      .fit_o      (fit_vec[g]),
      .give_ovf_o (ovf_vec[g]),
      .free_o     (free_flat[g*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    req_grant = req_valid && req_legal && fit_vec[req_idx];
    ret_err   = ret_valid && (!ret_legal || (|ovf_vec));
  end
endmodule

// File: rtl/vc_admit_chk.sv
module vc_admit_chk #(
  parameter  int unsigned CAP_PHITS = 24,
  parameter  int unsigned NUM_VC    = 19,
  localparam int unsigned CNT_W     = $clog2(CAP_PHITS + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [2:0]              req_class,
  input logic                    req_grant,
  input logic                    ret_valid,
  input logic                    ret_err,
  input logic [NUM_VC*CNT_W-1:0] free_flat
);
  a_r2_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_grant);

  a_r1_none_class_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 3'd7) |-> !req_grant);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_grant && !ret_valid) |=> $stable(free_flat));

  a_r5_err_no_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_err && !req_grant) |=> $stable(free_flat));

  for (genvar i = 0; i < NUM_VC; i++) begin : g_cap
    a_r8_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
      free_flat[i*CNT_W +: CNT_W] <= CNT_W'(CAP_PHITS));
  end
endmodule

bind vc_admit vc_admit_chk #(
  .CAP_PHITS (CAP_PHITS),
  .NUM_VC    (vc_admit_pkg::NUM_VC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_class (req_class),
  .req_grant (req_grant),
  .ret_valid (ret_valid),
  .ret_err   (ret_err),
  .free_flat (free_flat)
);

// File: tb/vc_admit_test.sv
module vc_admit_test;
  localparam int CAP   = 24;
  localparam int LEN_W = 7;
  localparam int CNT_W = 5;
  localparam int NVC   = 19;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, ret_valid;
  logic [2:0] req_class, ret_class;
  logic [1:0] req_lane, ret_lane;
  logic [LEN_W-1:0] req_len;
  logic [CNT_W-1:0] ret_phits;
  logic req_grant, ret_err;
  logic [NVC*CNT_W-1:0] free_flat;

  int model [NVC];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vc_admit #(.CAP_PHITS(CAP), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_class(req_class), .req_lane(req_lane),
    .req_len(req_len), .req_grant(req_grant),
    .ret_valid(ret_valid), .ret_class(ret_class), .ret_lane(ret_lane),
    .ret_phits(ret_phits), .ret_err(ret_err), .free_flat(free_flat)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int vc_of(int c, int l);
    if (c < 6 && l < 3) return c * 3 + l;
    if (c == 6 && l == 0) return 18;
    return -1;
  endfunction

  task automatic check_free(string tag);
    for (int i = 0; i < NVC; i++) begin
      check(tag, $sformatf("free[%0d]", i), int'(free_flat[i*CNT_W +: CNT_W]), model[i]);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NVC; i++) model[i] = CAP;
  endtask

  // One cycle: drive at falling edge, check combinational outputs and state,
  // then advance the reference model at the rising edge.
  task automatic cyc(bit rv, int rc, int rl, int len,
                     bit cv, int cc, int cl, int amt, string tag);
    int ri, ci, ph;
    bit eg, eo, ee;
    @(negedge clk);
    req_valid = rv; req_class = 3'(rc); req_lane = 2'(rl); req_len = LEN_W'(len);
    ret_valid = cv; ret_class = 3'(cc); ret_lane = 2'(cl); ret_phits = CNT_W'(amt);
    #1;
    ri = vc_of(rc, rl);
    ci = vc_of(cc, cl);
    ph = (len + 3) / 4;
    eg = rv && (ri >= 0) && (ph <= model[ri]);
    eo = cv && (ci >= 0) && (model[ci] + amt > CAP);
    ee = cv && ((ci < 0) || eo);
    check(tag, "req_grant", int'(req_grant), int'(eg));
    check(tag, "ret_err", int'(ret_err), int'(ee));
    check_free(tag);
    @(posedge clk);
    if (eg) model[ri] -= ph;
    if (cv && ci >= 0 && !eo) model[ci] += amt;
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_class = 0; req_lane = 0; req_len = 0;
    ret_valid = 0; ret_class = 0; ret_lane = 0; ret_phits = 0;
    model_reset();
    #10;
    check_free("R7");                         // all VCs at capacity in reset
    @(negedge clk);
    rst_n = 1'b1;
    idle("R7");

    cyc(1, 0, 0, 12, 0, 0, 0, 0, "R2");       // 3 phits, VC0 -> 21
    cyc(1, 4, 1, 76, 0, 0, 0, 0, "R2");       // 19 phits, VC13 -> 5
    cyc(1, 4, 1, 76, 0, 0, 0, 0, "R2");       // does not fit whole: refused
    cyc(1, 4, 1, 20, 0, 0, 0, 0, "R2");       // exactly 5 phits: granted, -> 0
    cyc(1, 4, 1, 1, 0, 0, 0, 0, "R2");        // empty VC refuses 1 phit
    cyc(1, 2, 2, 25, 0, 0, 0, 0, "R3");       // 25 bytes rounds to 7 phits
    cyc(1, 3, 0, 8, 0, 0, 0, 0, "R3");        // 2 phits
    idle("R3");
    cyc(1, 7, 0, 4, 0, 0, 0, 0, "R1");        // illegal class
    cyc(1, 6, 1, 4, 0, 0, 0, 0, "R1");        // special has lane 0 only
    cyc(1, 0, 3, 4, 0, 0, 0, 0, "R1");        // lane 3 illegal
    cyc(1, 6, 0, 25, 0, 0, 0, 0, "R1");       // special -> index 18, 7 phits
    cyc(0, 0, 0, 0, 1, 4, 1, 24, "R4");       // VC13 0 -> 24
    cyc(0, 0, 0, 0, 1, 4, 1, 1, "R5");        // one over capacity
    cyc(0, 0, 0, 0, 1, 7, 0, 1, "R5");        // illegal return address
    cyc(0, 0, 0, 0, 1, 6, 2, 1, "R5");
    cyc(1, 0, 1, 76, 0, 0, 0, 0, "R6");       // VC1 -> 5
    cyc(1, 0, 1, 40, 1, 0, 1, 10, "R6");      // refused on 5, credit -> 15
    cyc(1, 0, 1, 40, 1, 0, 1, 5, "R6");       // 15-10+5 -> 10
    cyc(1, 0, 1, 40, 1, 0, 1, 20, "R6");      // 10+20 overflows: err; grant -> 0
    idle("R8");
    idle("R8");

    for (int k = 0; k < 400; k++) begin
      int c, l, len, amt;
      c   = $urandom_range(0, 7);
      l   = $urandom_range(0, 3);
      len = (k % 3 == 0) ? $urandom_range(0, 127) : 4 * $urandom_range(1, 19);
      amt = $urandom_range(0, 12);
      cyc(1'($urandom_range(0, 1)), c, l, len,
          1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 3), amt,
          "R8");
    end

    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 0; ret_valid = 0;
    model_reset();
    #1;
    check_free("R7");                         // mid-run reset refills all VCs
    @(negedge clk);
    rst_n = 1'b1;
    idle("R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule